// File: doc/BRIEF.md
# Supervised-Aware Store Buffer

This block sits between a core that keeps total store order and its memory port. Retired stores enter a small FIFO and leave for memory oldest first. Each entry keeps the store's virtual address, its data and a flag that marks a supervised store. Only a supervised store has its metadata checked by memory.

A plain load asks the buffer whether a store to the same address is still waiting. If one is, the data of the youngest such store comes back. Otherwise the load is told to read memory. A supervised load never takes data from the buffer. While any matching store is still buffered it is told to wait and retry, and it is released to memory once none remains.

When memory reports a failed metadata check on a draining supervised store, that store still retires. The buffer then freezes. It raises a late-exception flag with the faulting virtual address, stops draining and stops accepting stores. A deferred handler reads the remaining entries out one at a time, oldest first, through a dump port, and then empties the buffer with a clear pulse.

Top module: `store_queue_supv`

## Requirements
- R1: The buffer holds DEPTH entries (default 4, a power of two). `st_ready` is low whenever DEPTH entries are held, and a store is accepted only in a cycle where `st_valid` and `st_ready` are both high.
- R2: Stores are offered on the drain port strictly in acceptance order. An offered store holds its address and data until `mem_wr_ack`.
- R3: One cycle after a plain load request (`ld_req`=1, `ld_supv`=0) whose address matches buffered stores, `ld_fwd_vld`=1 and `ld_fwd_data` carries the data of the youngest matching store.
- R4: One cycle after a plain load request with no matching buffered store, `ld_mem_go`=1 and `ld_fwd_vld`=0.
- R5: A supervised load request (`ld_supv`=1) never gives `ld_fwd_vld`=1. One cycle later `ld_wait`=1 if a matching store is buffered, otherwise `ld_mem_go`=1. At most one of the three load results is high in any cycle.
- R6: The drain and dump ports present the store's virtual address, data and supervised flag as they were accepted.
- R7: When `mem_exc` is high with the acknowledged drain of a supervised entry, that entry retires. In the next cycle `exc_flag`=1 and `exc_addr` holds its address. `mem_exc` with the drain of a plain entry has no effect.
- R8: While `exc_flag`=1, `st_ready`=0 and `mem_wr_valid`=0. `dump_valid` presents the remaining entries oldest first, and each `dump_next` pulse moves to the next one until none remain.
- R9: A `dump_clr` pulse while `exc_flag`=1 empties the buffer. From the next cycle `exc_flag`=0, `dump_valid`=0 and `st_ready`=1, and the entries that were dumped are never drained.
- R10: After reset the buffer is empty: `st_ready`=1, `mem_wr_valid`=0, `exc_flag`=0 and all load results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered by the core |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store virtual address |
| st_data | input | DW | Store data |
| st_supv | input | 1 | Store is supervised |
| ld_req | input | 1 | Load lookup request |
| ld_addr | input | AW | Load address |
| ld_supv | input | 1 | Load is supervised |
| ld_fwd_vld | output | 1 | Plain load served from the buffer |
| ld_fwd_data | output | DW | Forwarded data |
| ld_mem_go | output | 1 | Load may read memory |
| ld_wait | output | 1 | Supervised load must retry |
| mem_wr_valid | output | 1 | Oldest store offered to memory |
| mem_wr_addr | output | AW | Drain address |
| mem_wr_data | output | DW | Drain data |
| mem_wr_supv | output | 1 | Drained store is supervised |
| mem_wr_ack | input | 1 | Memory takes the offered store |
| mem_exc | input | 1 | Metadata check failed on the acknowledged store |
| exc_flag | output | 1 | Late exception pending, buffer frozen |
| exc_addr | output | AW | Virtual address of the faulting store |
| dump_valid | output | 1 | A remaining entry is presented |
| dump_addr | output | AW | Dumped entry address |
| dump_data | output | DW | Dumped entry data |
| dump_supv | output | 1 | Dumped entry is supervised |
| dump_next | input | 1 | Advance to the next dumped entry |
| dump_clr | input | 1 | Empty the buffer and resume |

## Verification
The assertions assume that memory raises `mem_exc` only together with `mem_wr_ack`, and that `dump_next` and `dump_clr` are pulsed only while `exc_flag` is high. They also assume the core treats a load result as answering the request it made one cycle earlier. The stimulus follows these rules. Memory responses come from a model that derives `mem_wr_ack` from an enable and `mem_wr_valid`, and raises `mem_exc` only on an acknowledged drain of a chosen address. The dump signals are pulsed only after the flag has been seen high.

// File: rtl/stq_pkg.sv
package stq_pkg;
  typedef enum logic {
    M_RUN  = 1'b0,
    M_DUMP = 1'b1
  } stq_mode_e;
endpackage

// File: rtl/stq_store.sv
module stq_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [PW-1:0]               widx,
  input  logic [AW-1:0]               waddr,
  input  logic [DW-1:0]               wdata,
  input  logic                        wsupv,
  input  logic [PW-1:0]               ridx_a,
  output logic [AW-1:0]               ra_addr,
  output logic [DW-1:0]               ra_data,
  output logic                        ra_supv,
  input  logic [PW-1:0]               ridx_b,
  output logic [AW-1:0]               rb_addr,
  output logic [DW-1:0]               rb_data,
  output logic                        rb_supv,
  output logic [DEPTH-1:0][AW-1:0]    all_addr,
  output logic [DEPTH-1:0][DW-1:0]    all_data
);
  logic [DEPTH-1:0] supv_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && widx == PW'(g)) begin
        all_addr[g] <= waddr;
        all_data[g] <= wdata;
        supv_q[g]   <= wsupv;
      end
    end
  end

  assign ra_addr = all_addr[ridx_a];
  assign ra_data = all_data[ridx_a];
  assign ra_supv = supv_q[ridx_a];
  assign rb_addr = all_addr[ridx_b];
  assign rb_data = all_data[ridx_b];
  assign rb_supv = supv_q[ridx_b];
endmodule

// File: rtl/stq_match.sv
module stq_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic [DEPTH-1:0][AW-1:0] all_addr,
  input  logic [DEPTH-1:0][DW-1:0] all_data,
  input  logic [PW-1:0]            head,
  input  logic [CW-1:0]            occ,
  input  logic [AW-1:0]            q_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);
  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    logic [PW-1:0] idx;
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (CW'(k) < occ && all_addr[idx] == q_addr) begin
        hit      = 1'b1;
        hit_data = all_data[idx];
      end
    end
  end
endmodule

// File: rtl/store_queue_supv.sv
module store_queue_supv #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          st_supv,
  input  logic          ld_req,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_supv,
  output logic          ld_fwd_vld,
  output logic [DW-1:0] ld_fwd_data,
  output logic          ld_mem_go,
  output logic          ld_wait,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          mem_wr_supv,
  input  logic          mem_wr_ack,
  input  logic          mem_exc,
  output logic          exc_flag,
  output logic [AW-1:0] exc_addr,
  output logic          dump_valid,
  output logic [AW-1:0] dump_addr,
  output logic [DW-1:0] dump_data,
  output logic          dump_supv,
  input  logic          dump_next,
  input  logic          dump_clr
);
  import stq_pkg::*;

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  stq_mode_e       mode;
  logic [PW-1:0]   head, tail, dump_ptr;
  logic [CW-1:0]   occ, occ_nx, dump_left;
  logic            in_run, push, pop, fault, hit;
  logic [DW-1:0]   hit_data;
  logic [DEPTH-1:0][AW-1:0] all_addr;
  logic [DEPTH-1:0][DW-1:0] all_data;

  assign in_run       = (mode == M_RUN);
  assign st_ready     = in_run && (occ != CW'(DEPTH));
  assign push         = st_valid && st_ready;
  assign mem_wr_valid = in_run && (occ != '0);
  assign pop          = mem_wr_valid && mem_wr_ack;
  assign fault        = pop && mem_exc && mem_wr_supv;
  assign occ_nx       = occ + CW'(push) - CW'(pop);
  assign exc_flag     = (mode == M_DUMP);
  assign dump_valid   = exc_flag && (dump_left != '0);

  stq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .we      (push),
    .widx    (tail),
    .waddr   (st_addr),
    .wdata   (st_data),
    .wsupv   (st_supv),
    .ridx_a  (head),
    .ra_addr (mem_wr_addr),
    .ra_data (mem_wr_data),
    .ra_supv (mem_wr_supv),
    .ridx_b  (dump_ptr),
    .rb_addr (dump_addr),
    .rb_data (dump_data),
    .rb_supv (dump_supv),
    .all_addr(all_addr),
    .all_data(all_data)
  );

  stq_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .all_addr(all_addr),
    .all_data(all_data),
    .head    (head),
    .occ     (occ),
    .q_addr  (ld_addr),
    .hit     (hit),
    .hit_data(hit_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      tail      <= '0;
      occ       <= '0;
      mode      <= M_RUN;
      dump_ptr  <= '0;
      dump_left <= '0;
      exc_addr  <= '0;
    end else if (exc_flag && dump_clr) begin
      head      <= tail;
      occ       <= '0;
      dump_left <= '0;
      mode      <= M_RUN;
    end else begin
      if (push) tail <= tail + PW'(1);
      if (pop)  head <= head + PW'(1);
      occ <= occ_nx;
      if (fault) begin
        mode      <= M_DUMP;
        exc_addr  <= mem_wr_addr;
        dump_ptr  <= head + PW'(1);
        dump_left <= occ_nx;
      end else if (exc_flag && dump_next && dump_left != '0) begin
        dump_ptr  <= dump_ptr + PW'(1);
        dump_left <= dump_left - CW'(1);
      end
    end
  end

  // Load results are registered and answer the request of the previous cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_fwd_vld  <= 1'b0;
      ld_fwd_data <= '0;
      ld_mem_go   <= 1'b0;
      ld_wait     <= 1'b0;
    end else begin
      ld_fwd_vld  <= ld_req && !ld_supv && hit;
      ld_fwd_data <= hit_data;
      ld_mem_go   <= ld_req && !hit;
      ld_wait     <= ld_req && ld_supv && hit;
    end
  end
endmodule

// File: rtl/stq_chk.sv
module stq_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic [$clog2(DEPTH):0] occ,
  input logic                   st_ready,
  input logic                   ld_req,
  input logic                   ld_supv,
  input logic                   ld_fwd_vld,
  input logic                   ld_mem_go,
  input logic                   ld_wait,
  input logic                   mem_wr_valid,
  input logic [AW-1:0]          mem_wr_addr,
  input logic                   mem_wr_supv,
  input logic                   mem_wr_ack,
  input logic                   mem_exc,
  input logic                   exc_flag,
  input logic [AW-1:0]          exc_addr,
  input logic                   dump_valid,
  input logic                   dump_clr
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    occ == ($clog2(DEPTH)+1)'(DEPTH) |-> !st_ready);

  p_drain_hold_r2: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ack |=> mem_wr_valid && $stable(mem_wr_addr));

  p_no_supv_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    ld_req && ld_supv |=> !ld_fwd_vld);

  p_one_result_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_fwd_vld, ld_mem_go, ld_wait}));

  p_late_exc_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && mem_wr_ack && mem_exc && mem_wr_supv
    |=> exc_flag && exc_addr == $past(mem_wr_addr));

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    exc_flag |-> !st_ready && !mem_wr_valid);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    exc_flag && dump_clr |=> !exc_flag && !dump_valid && st_ready);
endmodule

bind store_queue_supv stq_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .occ(occ), .st_ready(st_ready),
  .ld_req(ld_req), .ld_supv(ld_supv), .ld_fwd_vld(ld_fwd_vld),
  .ld_mem_go(ld_mem_go), .ld_wait(ld_wait), .mem_wr_valid(mem_wr_valid),
  .mem_wr_addr(mem_wr_addr), .mem_wr_supv(mem_wr_supv),
  .mem_wr_ack(mem_wr_ack), .mem_exc(mem_exc), .exc_flag(exc_flag),
  .exc_addr(exc_addr), .dump_valid(dump_valid), .dump_clr(dump_clr)
);

// File: tb/tb_store_queue_supv.sv
module tb_store_queue_supv;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic st_valid = 0, st_supv = 0, ld_req = 0, ld_supv = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0, fault_addr = '1;
  logic [DW-1:0] st_data = '0;
  logic dump_next = 0, dump_clr = 0, ack_en = 0;
  logic st_ready, ld_fwd_vld, ld_mem_go, ld_wait, mem_wr_valid, mem_wr_supv;
  logic mem_wr_ack, mem_exc, exc_flag, dump_valid, dump_supv;
  logic [DW-1:0] ld_fwd_data, mem_wr_data, dump_data;
  logic [AW-1:0] mem_wr_addr, exc_addr, dump_addr;

  always_comb begin
    mem_wr_ack = ack_en && mem_wr_valid;
    mem_exc    = mem_wr_ack && (mem_wr_addr == fault_addr);
  end

  store_queue_supv #(.DEPTH(4), .AW(AW), .DW(DW)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [AW+DW:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_st(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s, input bit drains);
    @(posedge clk); #1;
    st_valid = 1; st_addr = a; st_data = d; st_supv = s;
    if (drains) exp_q.push_back({s, a, d});
    @(posedge clk); #1;
    st_valid = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic s);
    @(posedge clk); #1;
    ld_req = 1; ld_addr = a; ld_supv = s;
    @(posedge clk); #1;
    ld_req = 0;
    @(negedge clk);
  endtask

  // Scoreboard monitor: every accepted drain must be the oldest expected store.
  always @(negedge clk) begin
    if (!rst && mem_wr_valid && mem_wr_ack) begin
      logic [AW+DW:0] e;
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected drain", mem_wr_addr, 0);
      end else begin
        e = exp_q.pop_front();
        chk({mem_wr_supv, mem_wr_addr, mem_wr_data} == e, "R2/R6 drain order",
            {mem_wr_supv, mem_wr_addr, mem_wr_data}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    chk(st_ready && !mem_wr_valid && !exc_flag && !ld_fwd_vld && !ld_mem_go && !ld_wait,
        "R10 reset state", {st_ready, mem_wr_valid, exc_flag}, 3'b100);

    // Fill with ack held off.
    push_st(32'h100, 32'h11, 0, 1);
    push_st(32'h104, 32'h22, 1, 1);
    push_st(32'h100, 32'h33, 0, 1);
    push_st(32'h108, 32'h44, 0, 1);
    @(negedge clk);
    chk(!st_ready, "R1 full stalls", st_ready, 0);

    do_load(32'h100, 0);
    chk(ld_fwd_vld && ld_fwd_data == 32'h33, "R3 youngest forward", ld_fwd_data, 32'h33);
    do_load(32'h200, 0);
    chk(ld_mem_go && !ld_fwd_vld, "R4 miss to memory", {ld_mem_go, ld_fwd_vld}, 2'b10);
    do_load(32'h100, 1);
    chk(ld_wait && !ld_fwd_vld && !ld_mem_go, "R5 supervised waits", {ld_wait, ld_fwd_vld, ld_mem_go}, 3'b100);
    do_load(32'h10C, 1);
    chk(ld_mem_go && !ld_wait, "R5 supervised no match", {ld_mem_go, ld_wait}, 2'b10);
    chk(mem_wr_valid && mem_wr_addr == 32'h100 && mem_wr_data == 32'h11,
        "R6 head offered", mem_wr_addr, 32'h100);

    // Fault reported on plain entries must be ignored (R7).
    fault_addr = 32'h100;
    @(posedge clk); #1; ack_en = 1;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!exc_flag && !mem_wr_valid, "R7 plain fault ignored", exc_flag, 0);
    do_load(32'h104, 1);
    chk(ld_mem_go && !ld_wait, "R5 released after drain", ld_mem_go, 1);

    // Late exception on a supervised store.
    ack_en = 0;
    fault_addr = 32'h200;
    push_st(32'h200, 32'h55, 1, 1);
    push_st(32'h204, 32'h66, 0, 0);
    push_st(32'h208, 32'h77, 1, 0);
    push_st(32'h20C, 32'h88, 0, 0);
    @(posedge clk); #1; ack_en = 1;
    while (!exc_flag) @(negedge clk);
    chk(exc_addr == 32'h200, "R7 exception address", exc_addr, 32'h200);
    chk(!st_ready && !mem_wr_valid, "R8 frozen", {st_ready, mem_wr_valid}, 0);
    chk(dump_valid && dump_addr == 32'h204 && dump_data == 32'h66 && !dump_supv,
        "R8 dump first", dump_addr, 32'h204);
    @(posedge clk); #1; dump_next = 1; @(posedge clk); #1; dump_next = 0; @(negedge clk);
    chk(dump_valid && dump_addr == 32'h208 && dump_data == 32'h77 && dump_supv,
        "R8 dump second", dump_addr, 32'h208);
    @(posedge clk); #1; dump_next = 1; @(posedge clk); #1; dump_next = 0; @(negedge clk);
    chk(dump_valid && dump_addr == 32'h20C && dump_data == 32'h88,
        "R8 dump third", dump_addr, 32'h20C);
    @(posedge clk); #1; dump_next = 1; @(posedge clk); #1; dump_next = 0; @(negedge clk);
    chk(!dump_valid && !mem_wr_valid, "R8 dump exhausted", dump_valid, 0);

    @(posedge clk); #1; dump_clr = 1; @(posedge clk); #1; dump_clr = 0; @(negedge clk);
    chk(!exc_flag && st_ready && !mem_wr_valid, "R9 cleared", {exc_flag, st_ready, mem_wr_valid}, 3'b010);

    // After clear only the new store may drain (monitor checks it).
    push_st(32'h300, 32'h99, 0, 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!mem_wr_valid, "R9 nothing stale drains", mem_wr_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule